// File: doc/BRIEF.md
# Per-Core Job Sequence Tracker

This block keeps the books for work handed to an array of hashing cores. Each core can hold two jobs at once: one it is working on and one queued behind it. Every job accepted through the issue port is stamped with the current value of a wrapping sequence counter. The core remembers the stamp of the last job it received.

Cores send status reports back. Each report carries a sequence number and, for every core, a busy bit for the active slot and one for the pending slot. A report may still describe the state from before the most recent issue to a core. For that reason the tracker applies a core's busy bits only when the reported sequence has reached or passed that core's last stamp, measured as a modular distance. When the busy bits are applied, they retire jobs, promote the pending job, or record that both slots were seen busy.

Outputs give the in-flight count for each core, a slot-free flag for each core, and the total in flight. The issue port signals acceptance or rejection one cycle after the request.

Top module: `job_seq_tracker`

## Requirements
- R1: Each core's in-flight count is 0, 1 or 2. `slot_free[i]` is high exactly when core i is enabled and its count is below 2. Core i's count sits at `inflight_cnt[2*i+1:2*i]`.
- R2: The sequence counter starts at 0 after reset. An accepted issue raises `issue_ok` on the next cycle, with `issue_seq` equal to the counter value before the issue. The counter then advances by one and the core's count rises by one.
- R3: The counter wraps modulo `SEQ_RANGE`, so the value after `SEQ_RANGE-1` is 0.
- R4: A report with sequence rx is trusted for core i only if the core's last stamp is tx and (rx − tx) mod `SEQ_RANGE` is less than `SEQ_RANGE/2`. Bits of `stat_seq` above the range are therefore ignored. An untrusted report leaves the core's count and flag unchanged.
- R5: For a trusted report in which core i's active bit and pending bit are both 0, the core's count becomes 0.
- R6: For a trusted report in which exactly one of core i's busy bits is 1, a count of 2 becomes 1 (the older job retires and the pending job is promoted), and a count of 1 stays 1.
- R7: For a trusted report in which both of core i's busy bits are 1, `seen_allbusy[i]` is set. It is cleared only by the next issue accepted to that core.
- R8: An issue to a core whose count is 2 raises `issue_err` on the next cycle. The count does not change and the counter does not advance.
- R9: While `core_en[i]` is 0, issues to core i are rejected with `issue_err`, and reports leave core i unchanged.
- R10: `total_inflight` equals the sum of all per-core counts and never exceeds NUM_CHIPS × CORES_PER_CHIP × 2.
- R11: When an issue is accepted to a core in the same cycle that a report arrives, the report is ignored for that core.
- R12: After reset, all counts, flags, `issue_ok`, `issue_err` and `issue_seq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_en | input | NUM_CORES | Enable for each core |
| issue_valid | input | 1 | Issue request |
| issue_core | input | CORE_W | Target core of the issue |
| stat_valid | input | 1 | Status report present |
| stat_seq | input | 16 | Sequence number carried by the report |
| stat_busy_act | input | NUM_CORES | Active-slot busy bit for each core |
| stat_busy_pend | input | NUM_CORES | Pending-slot busy bit for each core |
| issue_ok | output | 1 | Previous cycle's issue was accepted |
| issue_err | output | 1 | Previous cycle's issue was rejected |
| issue_seq | output | 16 | Stamp given to the accepted issue |
| inflight_cnt | output | 2*NUM_CORES | Count for each core, 2 bits per core |
| slot_free | output | NUM_CORES | Core can accept an issue |
| seen_allbusy | output | NUM_CORES | Both slots of the core seen busy since its last issue |
| total_inflight | output | TOT_W | Sum of all counts |

## Verification
The hardest case to reach from the ports is a report whose distance to a core's stamp falls right at the half-range limit once the counter has wrapped. A second hard case is a report that arrives in the same cycle as an issue to the same core. The stimulus first runs a core through more issue/retire pairs than the range holds, so the stamps wrap. It then places reports at distances of exactly half the range and one less, and finally drives an issue and a covering report together in one cycle.

// File: rtl/seq_tracker_pkg.sv
package seq_tracker_pkg;
  localparam int SEQ_W = 16;

  typedef enum logic [1:0] {ACT_NONE, ACT_CLEAR, ACT_POP, ACT_MARK} slot_act_e;

  // True when rx has reached or passed tx within half the sequence range.
  function automatic logic seq_covers(input logic [SEQ_W-1:0] rx,
                                      input logic [SEQ_W-1:0] tx,
                                      input logic [SEQ_W:0]   range_v);
    logic [SEQ_W:0] d;
    d = ({1'b0, rx} - {1'b0, tx}) & (range_v - 1'b1);
    return d < (range_v >> 1);
  endfunction
endpackage

// File: rtl/seq_tracker_issue.sv
module seq_tracker_issue
  import seq_tracker_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int SEQ_RANGE = 16,
  parameter int CORE_W    = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           issue_valid,
  input  logic [CORE_W-1:0]              issue_core,
  input  logic [NUM_CORES-1:0]           core_en,
  input  logic [NUM_CORES-1:0][1:0]      core_cnt,
  output logic [NUM_CORES-1:0]           grant,
  output logic [SEQ_W-1:0]               grant_seq,
  output logic                           issue_ok,
  output logic                           issue_err,
  output logic [SEQ_W-1:0]               issue_seq
);
  localparam logic [SEQ_W-1:0] SEQ_MASK = SEQ_W'(SEQ_RANGE - 1);

  logic [SEQ_W-1:0] ctr;
  logic [1:0]       sel_cnt;
  logic             sel_en;
  logic             accept;

  always_comb begin
    sel_cnt = 2'd2;
    sel_en  = 1'b0;
    for (int i = 0; i < NUM_CORES; i++) begin
      if (issue_core == CORE_W'(i)) begin
        sel_cnt = core_cnt[i];
        sel_en  = core_en[i];
      end
    end
    accept = issue_valid && sel_en && (sel_cnt != 2'd2);
    for (int i = 0; i < NUM_CORES; i++)
      grant[i] = accept && (issue_core == CORE_W'(i));
  end

  assign grant_seq = ctr;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctr       <= '0;
      issue_ok  <= 1'b0;
      issue_err <= 1'b0;
      issue_seq <= '0;
    end else begin
      issue_ok  <= accept;
      issue_err <= issue_valid && !accept;
      if (accept) begin
        issue_seq <= ctr;
        ctr       <= (ctr + 1'b1) & SEQ_MASK;
      end
    end
  end

  assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
    accept |=> issue_ok && issue_seq == $past(ctr));
  assert_seq_range_R3: assert property (@(posedge clk) disable iff (rst)
    ctr <= SEQ_MASK);
  assert_reject_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && !accept) |=> issue_err && $stable(ctr));
  assert_single_grant_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
endmodule

// File: rtl/seq_tracker_slot.sv
module seq_tracker_slot
  import seq_tracker_pkg::*;
#(
  parameter int SEQ_RANGE = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             grant,
  input  logic [SEQ_W-1:0] grant_seq,
  input  logic             stat_valid,
  input  logic [SEQ_W-1:0] stat_seq,
  input  logic             busy_act,
  input  logic             busy_pend,
  output logic [1:0]       cnt,
  output logic             allbusy,
  output logic             free
);
  localparam logic [SEQ_W:0] RANGE_V = (SEQ_W+1)'(SEQ_RANGE);

  logic [SEQ_W-1:0] last_seq;
  logic             trusted;
  slot_act_e        act;

  always_comb begin
    trusted = stat_valid && en && !grant && (cnt != 2'd0) &&
              seq_covers(stat_seq, last_seq, RANGE_V);
    act = ACT_NONE;
    if (trusted) begin
      case ({busy_act, busy_pend})
        2'b00:   act = ACT_CLEAR;
        2'b11:   act = ACT_MARK;
        default: act = ACT_POP;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= 2'd0;
      allbusy  <= 1'b0;
      last_seq <= '0;
    end else if (grant) begin
      cnt      <= 2'(cnt + 2'd1);
      last_seq <= grant_seq;
      allbusy  <= 1'b0;
    end else begin
      case (act)
        ACT_CLEAR: cnt <= 2'd0;
        ACT_POP:   if (cnt == 2'd2) cnt <= 2'd1;
        ACT_MARK:  allbusy <= 1'b1;
        default:   ;
      endcase
    end
  end

  assign free = en && (cnt != 2'd2);

  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (rst)
    cnt != 2'd3);
  assert_untrusted_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (stat_valid && !grant && !seq_covers(stat_seq, last_seq, RANGE_V))
    |=> $stable(cnt) && $stable(allbusy));
  assert_clear_idle_R5: assert property (@(posedge clk) disable iff (rst)
    (stat_valid && en && !grant && cnt != 2'd0 && !busy_act && !busy_pend &&
     seq_covers(stat_seq, last_seq, RANGE_V)) |=> cnt == 2'd0);
  assert_flag_clear_R7: assert property (@(posedge clk) disable iff (rst)
    grant |=> !allbusy);
  assert_grant_enabled_R9: assert property (@(posedge clk) disable iff (rst)
    grant |-> en);
  assert_issue_wins_R11: assert property (@(posedge clk) disable iff (rst)
    grant |=> cnt == 2'($past(cnt) + 2'd1));
endmodule

// File: rtl/job_seq_tracker.sv
module job_seq_tracker
  import seq_tracker_pkg::*;
#(
  parameter int NUM_CHIPS      = 2,
  parameter int CORES_PER_CHIP = 2,
  parameter int SEQ_RANGE      = 16,
  parameter int NUM_CORES      = NUM_CHIPS * CORES_PER_CHIP,
  parameter int CORE_W         = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  parameter int TOT_W          = $clog2(NUM_CORES * 2 + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_CORES-1:0]   core_en,
  input  logic                   issue_valid,
  input  logic [CORE_W-1:0]      issue_core,
  input  logic                   stat_valid,
  input  logic [15:0]            stat_seq,
  input  logic [NUM_CORES-1:0]   stat_busy_act,
  input  logic [NUM_CORES-1:0]   stat_busy_pend,
  output logic                   issue_ok,
  output logic                   issue_err,
  output logic [15:0]            issue_seq,
  output logic [2*NUM_CORES-1:0] inflight_cnt,
  output logic [NUM_CORES-1:0]   slot_free,
  output logic [NUM_CORES-1:0]   seen_allbusy,
  output logic [TOT_W-1:0]       total_inflight
);
  localparam int INFLIGHT_TARGET = NUM_CHIPS * CORES_PER_CHIP * 2;

  logic [NUM_CORES-1:0][1:0] slot_cnt;
  logic [NUM_CORES-1:0]      grant;
  logic [SEQ_W-1:0]          grant_seq;

  seq_tracker_issue #(
    .NUM_CORES(NUM_CORES), .SEQ_RANGE(SEQ_RANGE), .CORE_W(CORE_W)
  ) u_issue (
    .clk(clk), .rst(rst),
    .issue_valid(issue_valid), .issue_core(issue_core),
    .core_en(core_en), .core_cnt(slot_cnt),
    .grant(grant), .grant_seq(grant_seq),
    .issue_ok(issue_ok), .issue_err(issue_err), .issue_seq(issue_seq)
  );

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_slot
    seq_tracker_slot #(.SEQ_RANGE(SEQ_RANGE)) u_slot (
      .clk(clk), .rst(rst),
      .en(core_en[g]), .grant(grant[g]), .grant_seq(grant_seq),
      .stat_valid(stat_valid), .stat_seq(stat_seq),
      .busy_act(stat_busy_act[g]), .busy_pend(stat_busy_pend[g]),
      .cnt(slot_cnt[g]), .allbusy(seen_allbusy[g]), .free(slot_free[g])
    );
  end

  assign inflight_cnt = slot_cnt;

  always_comb begin
    total_inflight = '0;
    for (int i = 0; i < NUM_CORES; i++)
      total_inflight = total_inflight + TOT_W'(slot_cnt[i]);
  end

  assert_total_cap_R10: assert property (@(posedge clk) disable iff (rst)
    32'(total_inflight) <= INFLIGHT_TARGET);
  assert_disabled_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && !core_en[issue_core]) |=> issue_err && !issue_ok);
endmodule

// File: tb/job_seq_tracker_tb.sv
module job_seq_tracker_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  core_en = 4'b1111;
  logic        issue_valid = 1'b0;
  logic [1:0]  issue_core = '0;
  logic        stat_valid = 1'b0;
  logic [15:0] stat_seq = '0;
  logic [3:0]  stat_busy_act = '0;
  logic [3:0]  stat_busy_pend = '0;
  logic        issue_ok, issue_err;
  logic [15:0] issue_seq;
  logic [7:0]  inflight_cnt;
  logic [3:0]  slot_free, seen_allbusy;
  logic [3:0]  total_inflight;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  job_seq_tracker u_dut (
    .clk(clk), .rst(rst), .core_en(core_en),
    .issue_valid(issue_valid), .issue_core(issue_core),
    .stat_valid(stat_valid), .stat_seq(stat_seq),
    .stat_busy_act(stat_busy_act), .stat_busy_pend(stat_busy_pend),
    .issue_ok(issue_ok), .issue_err(issue_err), .issue_seq(issue_seq),
    .inflight_cnt(inflight_cnt), .slot_free(slot_free),
    .seen_allbusy(seen_allbusy), .total_inflight(total_inflight)
  );

  typedef struct packed {
    logic        is_issue;
    logic [1:0]  core;
    logic [15:0] seq;
    logic [3:0]  ba;
    logic [3:0]  bp;
    logic [7:0]  ecnt;
    logic        eerr;
    logic [15:0] eseq;
    logic [3:0]  eab;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd0, 16'd0,      4'b0000, 4'b0000, 8'b00000001, 1'b0, 16'd0, 4'b0000},
    '{1'b1, 2'd0, 16'd0,      4'b0000, 4'b0000, 8'b00000010, 1'b0, 16'd1, 4'b0000},
    '{1'b1, 2'd0, 16'd0,      4'b0000, 4'b0000, 8'b00000010, 1'b1, 16'd0, 4'b0000},
    '{1'b1, 2'd1, 16'd0,      4'b0000, 4'b0000, 8'b00000110, 1'b0, 16'd2, 4'b0000},
    '{1'b0, 2'd0, 16'd0,      4'b0000, 4'b0000, 8'b00000110, 1'b0, 16'd0, 4'b0000},
    '{1'b0, 2'd0, 16'd1,      4'b0001, 4'b0001, 8'b00000110, 1'b0, 16'd0, 4'b0001},
    '{1'b0, 2'd0, 16'd1,      4'b0001, 4'b0000, 8'b00000101, 1'b0, 16'd0, 4'b0001},
    '{1'b0, 2'd0, 16'd2,      4'b0000, 4'b0000, 8'b00000000, 1'b0, 16'd0, 4'b0001},
    '{1'b1, 2'd0, 16'd0,      4'b0000, 4'b0000, 8'b00000001, 1'b0, 16'd3, 4'b0000},
    '{1'b0, 2'd0, 16'h0013,   4'b0000, 4'b0000, 8'b00000000, 1'b0, 16'd0, 4'b0000}
  };

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drives one cycle of stimulus from a negative edge; returns at the next one.
  task automatic step(input logic iv, input logic [1:0] ic, input logic sv,
                      input logic [15:0] ss, input logic [3:0] ba,
                      input logic [3:0] bp);
    issue_valid = iv; issue_core = ic; stat_valid = sv;
    stat_seq = ss; stat_busy_act = ba; stat_busy_pend = bp;
    @(negedge clk);
    issue_valid = 1'b0; stat_valid = 1'b0;
    stat_busy_act = '0; stat_busy_pend = '0;
  endtask

  function automatic int cnt_of(input int c);
    return int'(inflight_cnt[2*c +: 2]);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int exp_ctr;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R12 reset state
    check("R12 counts", int'(inflight_cnt), 0);
    check("R12 flags", int'(seen_allbusy), 0);
    check("R12 ok/err", int'({issue_ok, issue_err}), 0);
    check("R12 seq", int'(issue_seq), 0);
    check("R1 free after reset", int'(slot_free), 4'b1111);

    // Table walk: R2 R4 R5 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      step(VEC[v].is_issue, VEC[v].core, !VEC[v].is_issue, VEC[v].seq,
           VEC[v].ba, VEC[v].bp);
      check($sformatf("R5/R6 counts vec %0d", v), int'(inflight_cnt), int'(VEC[v].ecnt));
      check($sformatf("R7 allbusy vec %0d", v), int'(seen_allbusy), int'(VEC[v].eab));
      if (VEC[v].is_issue) begin
        check($sformatf("R8 err vec %0d", v), int'(issue_err), int'(VEC[v].eerr));
        if (!VEC[v].eerr)
          check($sformatf("R2 seq vec %0d", v), int'(issue_seq), int'(VEC[v].eseq));
      end
    end
    exp_ctr = 4;

    // R3 wrap across more than one full range on core 2
    for (int k = 0; k < 18; k++) begin
      step(1'b1, 2'd2, 1'b0, 16'd0, 4'b0, 4'b0);
      check($sformatf("R3 wrap seq k=%0d", k), int'(issue_seq), exp_ctr);
      step(1'b0, 2'd0, 1'b1, 16'(exp_ctr), 4'b0, 4'b0);
      check($sformatf("R5 wrap retire k=%0d", k), cnt_of(2), 0);
      exp_ctr = (exp_ctr + 1) % 16;
    end

    // R4 half-range limit on core 0 (stamp 6)
    step(1'b1, 2'd0, 1'b0, 16'd0, 4'b0, 4'b0);
    check("R4 stamp", int'(issue_seq), 6);
    step(1'b0, 2'd0, 1'b1, 16'd14, 4'b0, 4'b0);
    check("R4 distance 8 untrusted", cnt_of(0), 1);
    step(1'b0, 2'd0, 1'b1, 16'd13, 4'b0, 4'b0);
    check("R4 distance 7 trusted", cnt_of(0), 0);

    // R11 issue and covering report in one cycle on core 3
    step(1'b1, 2'd3, 1'b0, 16'd0, 4'b0, 4'b0);
    check("R11 first stamp", int'(issue_seq), 7);
    step(1'b1, 2'd3, 1'b1, 16'd7, 4'b0, 4'b0);
    check("R11 report ignored", cnt_of(3), 2);
    check("R11 second stamp", int'(issue_seq), 8);

    // R7 and R6 on core 3
    step(1'b0, 2'd0, 1'b1, 16'd8, 4'b1000, 4'b1000);
    check("R7 flag set", int'(seen_allbusy[3]), 1);
    check("R7 count kept", cnt_of(3), 2);
    step(1'b0, 2'd0, 1'b1, 16'd8, 4'b1000, 4'b0000);
    check("R6 pop 2 to 1", cnt_of(3), 1);
    step(1'b0, 2'd0, 1'b1, 16'd8, 4'b0000, 4'b1000);
    check("R6 one stays one", cnt_of(3), 1);
    check("R7 flag held", int'(seen_allbusy[3]), 1);

    // R9 disabled core
    core_en = 4'b0111;
    step(1'b0, 2'd0, 1'b1, 16'd8, 4'b0, 4'b0);
    check("R9 report ignored", cnt_of(3), 1);
    check("R1 free disabled", int'(slot_free[3]), 0);
    step(1'b1, 2'd3, 1'b0, 16'd0, 4'b0, 4'b0);
    check("R9 issue rejected", int'(issue_err), 1);
    check("R9 count kept", cnt_of(3), 1);
    core_en = 4'b1111;
    step(1'b1, 2'd1, 1'b0, 16'd0, 4'b0, 4'b0);
    check("R8 counter not advanced", int'(issue_seq), 9);

    // R10 fill every slot
    check("R10 partial total", int'(total_inflight), 2);
    step(1'b1, 2'd0, 1'b0, 16'd0, 4'b0, 4'b0);
    step(1'b1, 2'd0, 1'b0, 16'd0, 4'b0, 4'b0);
    step(1'b1, 2'd2, 1'b0, 16'd0, 4'b0, 4'b0);
    step(1'b1, 2'd2, 1'b0, 16'd0, 4'b0, 4'b0);
    step(1'b1, 2'd1, 1'b0, 16'd0, 4'b0, 4'b0);
    step(1'b1, 2'd3, 1'b0, 16'd0, 4'b0, 4'b0);
    check("R3 last before wrap", int'(issue_seq), 15);
    check("R10 full total", int'(total_inflight), 8);
    check("R1 none free", int'(slot_free), 0);
    step(1'b1, 2'd2, 1'b0, 16'd0, 4'b0, 4'b0);
    check("R8 full reject", int'(issue_err), 1);
    check("R10 total held", int'(total_inflight), 8);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule